// File: doc/BRIEF.md
# Instruction Cache Tag and Refill Controller

This block keeps the tags, valid bits, lock bits and replacement state for a 32 KB instruction cache. The cache has eight ways, 64 sets and 64-byte blocks, so it holds 512 tagged blocks. A fetch address is looked up in one cycle. The result is reported on the next cycle, with the hitting way on a hit or the chosen victim way on a miss. On a miss the controller stalls the CPU and issues one block-aligned burst request to memory. It then streams the sixteen returned words into the data array through write strobes, always starting at the first word of the block. The block becomes valid only after the last word has arrived.

Software has two controls. A single-cycle command clears every valid bit, which is used for coherency. A per-way lock command pins a block so that it is never replaced. At most half of the ways in a set can be locked. Replacement uses a two-level pseudo-LRU: one bit inside each pair of ways, plus a three-bit tree that chooses among the four pairs. The descent skips any subtree whose ways are all locked. A constant output word reports the cache geometry.

Top module: `icache_ctrl`

## Requirements
- R1: `geometry` reads as sets in bits 31:16 (64), block bytes in bits 15:8 (64) and ways in bits 7:0 (8).
- R2: The address splits into a tag (bits 31:12), a set (bits 11:6) and an offset (bits 5:0). A fetch accepted while `stall` is low gives `resp_valid` on the next cycle. It sets `resp_hit`=1 with `resp_way` naming the way whose valid tag matches; a locked way still hits. Every accepted fetch gives exactly one response.
- R3: On a miss, one request is made with `mem_req_addr` equal to the fetch address with bits 5:0 cleared. The request is held until `mem_req_ready`. The sixteen 32-bit responses then drive `fill_we` with `fill_word` counting 0 to 15 in order, and `fill_way`/`fill_set` naming the victim. The block becomes valid only after word 15 has been written.
- R4: `stall` rises in the cycle after a miss is looked up. It stays high through the request and through any gaps between response words. It falls in the cycle after word 15 is written. A fetch presented while `stall` is high is ignored and gives no response.
- R5: If the set has an invalid, unlocked way, the victim is the lowest-numbered such way. Locked invalid ways are skipped.
- R6: Otherwise the victim is chosen by pseudo-LRU. Each set keeps a pair bit per way pair k, which names way 2k+bit. It also keeps a root bit (0 = ways 0-3, 1 = ways 4-7) and one bit per half that chooses the pair within that half. Every hit and every completed fill points all the bits on the accessed way's path away from that way. If a subtree has no unlocked way, the other subtree is taken.
- R7: A lock command (`lock_on`=1) on way `lock_way` of set `lock_set` succeeds unless the set already has four locked ways and that way is not among them. An unlock (`lock_on`=0) always succeeds. `lock_done` pulses on the next cycle, with `lock_ok` giving the outcome. A locked way is never chosen as a victim.
- R8: `inval_all` clears every valid bit in one cycle and leaves lock bits unchanged. When it coincides with another command, it has priority over the lock command, and the lock command has priority over a fetch.
- R9: After reset, `stall`, `resp_valid`, `mem_req_valid` and `lock_done` are low, and every way of every set is invalid and unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_addr | input | 32 | Fetch byte address |
| stall | output | 1 | CPU stall during refill |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 3 | Hitting way or chosen victim |
| mem_req_valid | output | 1 | Block refill request |
| mem_req_addr | output | 32 | Block-aligned refill address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | 32 | Refill word |
| fill_we | output | 1 | Data array write strobe |
| fill_way | output | 3 | Way being filled |
| fill_set | output | 6 | Set being filled |
| fill_word | output | 4 | Word index within the block |
| fill_data | output | 32 | Word to write |
| inval_all | input | 1 | Invalidate the whole cache |
| lock_valid | input | 1 | Lock or unlock command |
| lock_set | input | 6 | Set of the lock command |
| lock_way | input | 3 | Way of the lock command |
| lock_on | input | 1 | 1 = lock, 0 = unlock |
| lock_done | output | 1 | Lock command completed |
| lock_ok | output | 1 | Lock command accepted |
| geometry | output | 32 | Constant geometry word |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only after it has accepted a request, and no more than sixteen times per request. They also assume that lock and invalidate commands are issued only while `stall` is low. The bench keeps within these limits. Its memory model answers only after it has seen and acknowledged a request, and it returns exactly sixteen words. Its command tasks wait for `stall` to drop before driving anything. The only stimulus given during a stall is a deliberate fetch, used to show that such a fetch is ignored.

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SETS        = 64,
  parameter int BLOCK_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetch_valid,
  input  logic [ADDR_W-1:0]             fetch_addr,
  output logic                          stall,
  output logic                          resp_valid,
  output logic                          resp_hit,
  output logic [2:0]                    resp_way,
  output logic                          mem_req_valid,
  output logic [ADDR_W-1:0]             mem_req_addr,
  input  logic                          mem_req_ready,
  input  logic                          mem_rsp_valid,
  input  logic [DATA_W-1:0]             mem_rsp_data,
  output logic                          fill_we,
  output logic [2:0]                    fill_way,
  output logic [$clog2(SETS)-1:0]       fill_set,
  output logic [$clog2(BLOCK_BYTES/(DATA_W/8))-1:0] fill_word,
  output logic [DATA_W-1:0]             fill_data,
  input  logic                          inval_all,
  input  logic                          lock_valid,
  input  logic [$clog2(SETS)-1:0]       lock_set,
  input  logic [2:0]                    lock_way,
  input  logic                          lock_on,
  output logic                          lock_done,
  output logic                          lock_ok,
  output logic [31:0]                   geometry
);
  localparam int WAYS     = 8;
  localparam int MAX_LOCK = WAYS / 2;
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int WORDS    = BLOCK_BYTES / (DATA_W / 8);
  localparam int WORD_W   = $clog2(WORDS);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} state_t;
  state_t st;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  lk_q   [SETS];
  logic [3:0]       pair_q [SETS];
  logic [2:0]       tree_q [SETS];

  logic [IDX_W-1:0]  f_set, lk_set_q;
  logic [TAG_W-1:0]  f_tag;
  logic [2:0]        f_way;
  logic [WORD_W-1:0] cnt;

  wire [IDX_W-1:0] idx  = fetch_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] ftag = fetch_addr[ADDR_W-1 -: TAG_W];
  logic unused_ok;
  assign unused_ok = &{1'b0, fetch_addr[OFF_W-1:0]};

  logic [WAYS-1:0] hit_vec, free;
  logic            hit_any;
  logic [2:0]      hit_way, victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == ftag);
  end
  assign hit_any = |hit_vec;
  assign free    = ~vld_q[idx] & ~lk_q[idx];

  function automatic logic [2:0] lru_pick(input logic [3:0] p, input logic [2:0] t,
                                          input logic [7:0] e);
    logic [3:0] pe;
    logic       half, sub, lo, a, b;
    logic [1:0] pr;
    for (int k = 0; k < 4; k++) pe[k] = e[2*k] | e[2*k+1];
    a    = pe[0] | pe[1];
    b    = pe[2] | pe[3];
    half = (a && b) ? t[0] : b;
    a    = pe[{half, 1'b0}];
    b    = pe[{half, 1'b1}];
    sub  = (a && b) ? (half ? t[2] : t[1]) : b;
    pr   = {half, sub};
    a    = e[{pr, 1'b0}];
    b    = e[{pr, 1'b1}];
    lo   = (a && b) ? p[pr] : b;
    return {pr, lo};
  endfunction

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = 3'(w);
    victim = lru_pick(pair_q[idx], tree_q[idx], ~lk_q[idx]);
    for (int w = WAYS - 1; w >= 0; w--) if (free[w]) victim = 3'(w);
  end

  wire idle       = (st == S_IDLE);
  wire take_fetch = idle && !inval_all && !lock_valid && fetch_valid;
  wire start_fill = take_fetch && !hit_any;
  wire lock_room  = lk_q[lock_set][lock_way] || ($countones(lk_q[lock_set]) < MAX_LOCK);
  wire last_word  = fill_we && (cnt == WORD_W'(WORDS - 1));

  assign stall         = !idle;
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = {f_tag, f_set, {OFF_W{1'b0}}};
  assign fill_we       = (st == S_DATA) && mem_rsp_valid;
  assign fill_way      = f_way;
  assign fill_set      = f_set;
  assign fill_word     = cnt;
  assign fill_data     = mem_rsp_data;
  assign geometry      = {16'(SETS), 8'(BLOCK_BYTES), 8'(WAYS)};

  always_ff @(posedge clk) begin
    if (start_fill) tag_q[idx][victim] <= ftag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      lock_done  <= 1'b0;
      lock_ok    <= 1'b0;
      lk_set_q   <= '0;
      f_set      <= '0;
      f_tag      <= '0;
      f_way      <= '0;
      cnt        <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        lk_q[s]   <= '0;
        pair_q[s] <= '0;
        tree_q[s] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      lock_done  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (inval_all) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
          end else if (lock_valid) begin
            lock_done <= 1'b1;
            lk_set_q  <= lock_set;
            if (!lock_on) begin
              lk_q[lock_set][lock_way] <= 1'b0;
              lock_ok <= 1'b1;
            end else begin
              lock_ok <= lock_room;
              if (lock_room) lk_q[lock_set][lock_way] <= 1'b1;
            end
          end else if (fetch_valid) begin
            resp_valid <= 1'b1;
            resp_hit   <= hit_any;
            resp_way   <= hit_any ? hit_way : victim;
            if (hit_any) begin
              pair_q[idx][hit_way[2:1]] <= ~hit_way[0];
              tree_q[idx][0] <= ~hit_way[2];
              if (hit_way[2]) tree_q[idx][2] <= ~hit_way[1];
              else            tree_q[idx][1] <= ~hit_way[1];
            end else begin
              vld_q[idx][victim] <= 1'b0;
              f_set <= idx;
              f_tag <= ftag;
              f_way <= victim;
              cnt   <= '0;
              st    <= S_REQ;
            end
          end
        end
        S_REQ: if (mem_req_ready) st <= S_DATA;
        default: begin
          if (fill_we) begin
            cnt <= cnt + 1'b1;
            if (last_word) begin
              vld_q[f_set][f_way] <= 1'b1;
              pair_q[f_set][f_way[2:1]] <= ~f_way[0];
              tree_q[f_set][0] <= ~f_way[2];
              if (f_way[2]) tree_q[f_set][2] <= ~f_way[1];
              else          tree_q[f_set][1] <= ~f_way[1];
              st <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && idle) |-> $onehot0(hit_vec));

  p_resp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(fetch_valid && idle));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_valid_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !last_word) |=> !vld_q[f_set][f_way]);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !last_word) |=> stall);

  p_stall_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_fill |=> stall);

  p_victim_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_fill |-> !lk_q[idx][victim]);

  p_lock_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |-> ($countones(lk_q[lk_set_q]) <= MAX_LOCK));
endmodule

// File: tb/icache_ctrl_test.sv
module icache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        stall, resp_valid, resp_hit;
  logic [2:0]  resp_way;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_we;
  logic [2:0]  fill_way;
  logic [5:0]  fill_set;
  logic [3:0]  fill_word;
  logic [31:0] fill_data;
  logic        inval_all = 1'b0;
  logic        lock_valid = 1'b0;
  logic [5:0]  lock_set = '0;
  logic [2:0]  lock_way = '0;
  logic        lock_on = 1'b0;
  logic        lock_done, lock_ok;
  logic [31:0] geometry;

  always #10 clk = ~clk;

  icache_ctrl uut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit          exp_hit_q[$];
  logic [2:0]  exp_way_q[$];
  string       exp_req_q[$];
  logic [31:0] exp_block = '0;
  logic [2:0]  exp_fway = '0;
  logic [5:0]  exp_fset = '0;

  function automatic logic [31:0] mk(input logic [19:0] t, input logic [5:0] s,
                                     input logic [5:0] o);
    return {t, s, o};
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] blk, input int i);
    return (blk ^ 32'h5A00_0000) + 32'(i * 4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_hit_q.size() == 0) begin
        chk(1'b0, "R4", "response without accepted fetch", 32'd1, 32'd0);
      end else begin
        automatic bit         h = exp_hit_q.pop_front();
        automatic logic [2:0] w = exp_way_q.pop_front();
        automatic string      r = exp_req_q.pop_front();
        chk(resp_hit == h && resp_way == w, r, "hit/way",
            {28'd0, resp_hit, resp_way}, {28'd0, h, w});
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        chk(mem_req_addr == exp_block, "R3", "block-aligned request", mem_req_addr, exp_block);
        repeat (2) @(negedge clk);
        chk(mem_req_valid && stall, "R4", "request held with stall", {31'd0, mem_req_valid}, 32'd1);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < 16; i++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pat(exp_block, i);
          #1;
          chk(fill_we && fill_word == 4'(i) && fill_way == exp_fway &&
              fill_set == exp_fset && fill_data == pat(exp_block, i),
              "R3", "fill strobe order", {fill_set, fill_way, fill_word, fill_data[18:0]},
              {exp_fset, exp_fway, 4'(i), pat(exp_block, i)});
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          if (i % 2 == 0) begin
            #1 chk(stall, "R4", "stall in response gap", {31'd0, stall}, 32'd1);
            @(negedge clk);
          end
        end
        #1 chk(!stall, "R4", "stall released after last word", {31'd0, stall}, 32'd0);
      end
    end
  end

  task automatic fetch(input logic [19:0] t, input logic [5:0] s, input logic [5:0] o,
                       input bit h, input logic [2:0] w, input string req, input bit poke = 1'b0);
    @(negedge clk);
    while (stall) @(negedge clk);
    exp_hit_q.push_back(h);
    exp_way_q.push_back(w);
    exp_req_q.push_back(req);
    if (!h) begin
      exp_block = mk(t, s, 6'd0);
      exp_fway  = w;
      exp_fset  = s;
    end
    fetch_valid = 1'b1;
    fetch_addr  = mk(t, s, o);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(stall == !h, "R4", "stall after lookup", {31'd0, stall}, {31'd0, !h});
    if (!h && poke) begin
      fetch_valid = 1'b1;
      fetch_addr  = mk(20'd1, 6'd5, 6'd0);
      @(negedge clk);
      fetch_valid = 1'b0;
    end
    while (stall) @(negedge clk);
  endtask

  task automatic lock(input logic [5:0] s, input logic [2:0] w, input bit on, input bit exp_ok);
    @(negedge clk);
    while (stall) @(negedge clk);
    lock_valid = 1'b1;
    lock_set   = s;
    lock_way   = w;
    lock_on    = on;
    @(negedge clk);
    lock_valid = 1'b0;
    chk(lock_done && lock_ok == exp_ok, "R7", "lock outcome",
        {30'd0, lock_done, lock_ok}, {30'd0, 1'b1, exp_ok});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !resp_valid && !mem_req_valid && !lock_done, "R9", "reset outputs",
        {28'd0, stall, resp_valid, mem_req_valid, lock_done}, 32'd0);
    chk(geometry == {16'd64, 8'd64, 8'd8}, "R1", "geometry word", geometry,
        {16'd64, 8'd64, 8'd8});

    // R5 / R9: empty set fills ways in ascending order
    for (int k = 0; k < 8; k++)
      fetch(20'(k + 1), 6'd5, 6'h24, 1'b0, 3'(k), "R5", k == 2);
    fetch(20'd1, 6'd5, 6'h00, 1'b1, 3'd0, "R2");
    fetch(20'd8, 6'd5, 6'h3C, 1'b1, 3'd7, "R2");
    // R6: tree points to way 2, then to way 4 rather than oldest way 1
    fetch(20'd9,  6'd5, 6'h10, 1'b0, 3'd2, "R6");
    fetch(20'd10, 6'd5, 6'h00, 1'b0, 3'd4, "R6");

    // R7: lock limit and lock-aware descent
    for (int k = 0; k < 8; k++)
      fetch(20'(k + 1), 6'd9, 6'h00, 1'b0, 3'(k), "R5");
    for (int k = 0; k < 4; k++) lock(6'd9, 3'(k), 1'b1, 1'b1);
    lock(6'd9, 3'd4, 1'b1, 1'b0);
    lock(6'd9, 3'd0, 1'b1, 1'b1);
    fetch(20'd20, 6'd9, 6'h08, 1'b0, 3'd4, "R7");
    fetch(20'd21, 6'd9, 6'h08, 1'b0, 3'd6, "R7");
    lock(6'd9, 3'd0, 1'b0, 1'b1);
    lock(6'd9, 3'd5, 1'b1, 1'b1);
    lock(6'd9, 3'd6, 1'b1, 1'b0);
    fetch(20'd2, 6'd9, 6'h04, 1'b1, 3'd1, "R2");

    // R5: locked invalid ways are skipped
    lock(6'd12, 3'd0, 1'b1, 1'b1);
    lock(6'd12, 3'd1, 1'b1, 1'b1);
    fetch(20'd3, 6'd12, 6'h00, 1'b0, 3'd2, "R5");

    // R8: invalidate all, locks kept
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    chk(!resp_valid && !stall, "R8", "invalidate quiet", {30'd0, resp_valid, stall}, 32'd0);
    fetch(20'd1,  6'd5, 6'h00, 1'b0, 3'd0, "R8");
    fetch(20'd30, 6'd9, 6'h00, 1'b0, 3'd0, "R8");
    fetch(20'd31, 6'd9, 6'h00, 1'b0, 3'd4, "R8");
    lock(6'd9, 3'd6, 1'b1, 1'b0);

    repeat (5) @(negedge clk);
    chk(exp_hit_q.size() == 0, "R2", "all responses seen", 32'(exp_hit_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule